// File: doc/BRIEF.md
# Sparse Column Multiply-Accumulate Element

This block is a single processing element for sparse matrix by sparse vector products. A column of the weight matrix is held in compressed form. Each stored byte pairs a 4-bit weight code with a 4-bit count of the zero rows skipped before it. A per-column pointer table marks where each column's bytes begin and end. The element receives requests, each an activation value with the index of the column it scales. It queues them and walks the stored bytes of each requested column in order. For every byte it decodes the weight through a 16-entry codebook and adds the scaled product into the output accumulator of the matching row.

Each update goes through four stages. Stage 1 looks up the codebook and forms the row address. Stage 2 reads the accumulator and multiplies in parallel. Stage 3 shifts and adds with saturation. Stage 4 writes the result back. The pointer table, the packed byte store and the codebook are loaded through plain write ports. The accumulators are cleared by reset and read through a combinational read port. A one-cycle `done` pulse marks the moment the element has drained all queued work.

Top module: `csc_pe`

## Requirements
- R1: Packed byte k lives in store word k/8 at bits 8*(k%8)+7 down to 8*(k%8). Within a byte, bits 3:0 are the weight code and bits 7:4 are the zero-run count.
- R2: Pointer index j of the pointer table holds the first byte of column j. A request for column j processes bytes from pointer j up to pointer j+1 minus one, in increasing order. A column whose two pointers are equal changes no accumulator.
- R3: The first byte of a column targets row equal to its run count. Every later byte of the same column targets the previous row plus its run count plus one.
- R4: Weight code 0 always decodes to zero, whatever was written to codebook slot 0. A code-0 filler byte leaves every accumulator unchanged but still advances the row.
- R5: Each byte updates its row as acc = acc + ((codebook[code] * activation) >>> 8). All values are 16-bit signed, the codebook values and activation are in Q8.8, and the shift is arithmetic.
- R6: The addition saturates to 32767 and -32768 instead of wrapping.
- R7: When the last byte of one column and the first byte of the next column hit the same row, both contributions are accumulated.
- R8: A byte's accumulator write happens exactly three cycles after the cycle in which the byte is issued from the store.
- R9: `done` is high for a single cycle, in the cycle the last byte of a column is written back while the request queue is empty and no other byte is in flight.
- R10: After reset every accumulator reads 0, `done` is low and `in_ready` is high. `in_ready` is low once the request queue holds its full depth of 4 entries.
- R11: Queued requests are served in arrival order, and every accepted request contributes its full column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_col | input | 3 | Column index of the request |
| in_act | input | 16 | Signed Q8.8 activation of the request |
| in_ready | output | 1 | Request queue can accept |
| ptr_we | input | 1 | Pointer table write enable |
| ptr_waddr | input | 4 | Pointer index written |
| ptr_wdata | input | 7 | Byte position stored at that index |
| mem_we | input | 1 | Packed store write enable |
| mem_waddr | input | 3 | Store word written |
| mem_wdata | input | 64 | Eight packed bytes |
| cb_we | input | 1 | Codebook write enable |
| cb_waddr | input | 4 | Codebook slot |
| cb_wdata | input | 16 | Signed Q8.8 codebook value |
| rd_row | input | 5 | Accumulator row to read |
| rd_data | output | 16 | Value of that accumulator |
| done | output | 1 | Work drained pulse |

## Verification
The embedded properties rely on well-formed contents. Pointers must never decrease from one index to the next. Run counts must keep every row of a column inside the 32 accumulators and strictly increasing. Column indices must be in range. Under those conditions two entries in adjacent stages can never share a row, and only the write-back stage needs forwarding. The stimulus builds its matrix to meet all of this. It uses a filler byte with the largest run count, a column empty of bytes, two consecutive columns that meet on one row, and activations at both extremes to drive saturation.

// File: rtl/cscpe_pkg.sv
package cscpe_pkg;
    localparam int DW    = 16;
    localparam int FRAC  = 8;
    localparam int CODEW = 4;
    localparam int RUNW  = 4;
    localparam int ENTW  = CODEW + RUNW;
    localparam int MEMW  = 64;
    localparam int EPW   = MEMW / ENTW;
    localparam int NCODE = 1 << CODEW;
    localparam int SUMW  = 2 * DW + 2;

    typedef logic signed [DW-1:0] sword_t;

    typedef struct packed {
        logic [RUNW-1:0]  run;
        logic [CODEW-1:0] code;
    } entry_t;

    typedef enum logic {SQ_IDLE, SQ_WALK} sq_state_t;

    function automatic sword_t sat_dw(input logic signed [SUMW-1:0] v);
        logic signed [SUMW-1:0] hi;
        logic signed [SUMW-1:0] lo;
        hi = {{(SUMW-DW+1){1'b0}}, {(DW-1){1'b1}}};
        lo = {{(SUMW-DW+1){1'b1}}, {(DW-1){1'b0}}};
        if (v > hi)      return {1'b0, {(DW-1){1'b1}}};
        else if (v < lo) return {1'b1, {(DW-1){1'b0}}};
        else             return v[DW-1:0];
    endfunction
endpackage

// File: rtl/cscpe_queue.sv
module cscpe_queue #(
    parameter int W     = 19,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                slots[wp] <= din;
                wp        <= wp + AW'(1);
            end
            if (do_pop) rp <= rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    p_full_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/cscpe_ptr_banks.sv
module cscpe_ptr_banks #(
    parameter int NCOL = 8,
    parameter int PW   = 7
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [$clog2(NCOL+1)-1:0]  waddr,
    input  logic [PW-1:0]              wdata,
    input  logic [$clog2(NCOL)-1:0]    col,
    output logic [PW-1:0]              p_lo,
    output logic [PW-1:0]              p_hi
);
    localparam int PIW = $clog2(NCOL + 1);
    localparam int NEV = NCOL / 2 + 1;
    localparam int NOD = (NCOL + 1) / 2;

    logic [PW-1:0]  even_bank [NEV];
    logic [PW-1:0]  odd_bank  [NOD];
    logic [PIW-1:0] half;

    always_ff @(posedge clk) begin
        if (we) begin
            if (waddr[0]) odd_bank[waddr >> 1]  <= wdata;
            else          even_bank[waddr >> 1] <= wdata;
        end
    end

    assign half = PIW'(col) >> 1;

    always_comb begin
        if (!col[0]) begin
            p_lo = even_bank[half];
            p_hi = odd_bank[half];
        end else begin
            p_lo = odd_bank[half];
            p_hi = even_bank[half + PIW'(1)];
        end
    end
endmodule

// File: rtl/cscpe_spmat.sv
module cscpe_spmat
    import cscpe_pkg::*;
#(
    parameter int NWORD = 8
) (
    input  logic                              clk,
    input  logic                              we,
    input  logic [$clog2(NWORD)-1:0]          waddr,
    input  logic [MEMW-1:0]                   wdata,
    input  logic [$clog2(NWORD*EPW)-1:0]      idx,
    output entry_t                            ent
);
    localparam int IDXW = $clog2(NWORD * EPW);
    localparam int BSW  = $clog2(EPW);

    logic [MEMW-1:0] words [NWORD];
    logic [MEMW-1:0] line;

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign line = words[idx[IDXW-1:BSW]];
    assign ent  = entry_t'(line[ENTW*idx[BSW-1:0] +: ENTW]);
endmodule

// File: rtl/cscpe_pipe.sv
module cscpe_pipe
    import cscpe_pkg::*;
#(
    parameter int NROW = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      iss_v,
    input  entry_t                    iss_ent,
    input  sword_t                    iss_act,
    input  logic                      iss_first,
    input  logic                      iss_last,
    input  logic                      cb_we,
    input  logic [CODEW-1:0]          cb_waddr,
    input  sword_t                    cb_wdata,
    input  logic [$clog2(NROW)-1:0]   rd_row,
    output sword_t                    rd_data,
    output logic                      busy,
    output logic                      wb_last
);
    localparam int ROWW = $clog2(NROW);

    typedef struct packed {
        logic             v;
        logic             first;
        logic             last;
        logic [CODEW-1:0] code;
        logic [ROWW-1:0]  row;
        sword_t           w;
        sword_t           act;
    } st1_t;

    typedef struct packed {
        logic                   v;
        logic                   last;
        logic [ROWW-1:0]        row;
        sword_t                 accv;
        logic signed [2*DW-1:0] prod;
    } st2_t;

    typedef struct packed {
        logic            v;
        logic            last;
        logic [ROWW-1:0] row;
        sword_t          sum;
    } st3_t;

    sword_t          cb  [NCODE];
    sword_t          acc [NROW];
    st1_t            s1;
    st2_t            s2;
    st3_t            s3;
    logic [ROWW-1:0] nbase, row_c;

    always_ff @(posedge clk) begin
        if (cb_we) cb[cb_waddr] <= cb_wdata;
    end

    // stage 1: codebook lookup alongside running row sum
    assign row_c = (iss_first ? '0 : nbase) + ROWW'(iss_ent.run);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1.v  <= 1'b0;
            nbase <= '0;
        end else begin
            s1.v <= iss_v;
            if (iss_v) begin
                s1.first <= iss_first;
                s1.last  <= iss_last;
                s1.code  <= iss_ent.code;
                s1.row   <= row_c;
                s1.w     <= (iss_ent.code == '0) ? '0 : cb[iss_ent.code];
                s1.act   <= iss_act;
                nbase    <= row_c + ROWW'(1);
            end
        end
    end

    // stage 2: accumulator read (write-back forwarded) alongside multiply
    sword_t                 acc_rd;
    logic signed [2*DW-1:0] prod_c;
    sword_t                 w_s, a_s;

    assign w_s    = s1.w;
    assign a_s    = s1.act;
    assign prod_c = w_s * a_s;
    assign acc_rd = (s3.v && s3.row == s1.row) ? s3.sum : acc[s1.row];

    always_ff @(posedge clk) begin
        if (rst) begin
            s2.v <= 1'b0;
        end else begin
            s2.v <= s1.v;
            if (s1.v) begin
                s2.last <= s1.last;
                s2.row  <= s1.row;
                s2.accv <= acc_rd;
                s2.prod <= prod_c;
            end
        end
    end

    // stage 3: shift and saturating add
    logic signed [2*DW-1:0] prod_s, prod_sh;
    sword_t                 accv_s;
    sword_t                 sum_c;

    assign prod_s  = s2.prod;
    assign accv_s  = s2.accv;
    assign prod_sh = prod_s >>> FRAC;
    assign sum_c   = sat_dw(SUMW'(accv_s) + SUMW'(prod_sh));

    always_ff @(posedge clk) begin
        if (rst) begin
            s3.v <= 1'b0;
        end else begin
            s3.v <= s2.v;
            if (s2.v) begin
                s3.last <= s2.last;
                s3.row  <= s2.row;
                s3.sum  <= sum_c;
            end
        end
    end

    // stage 4: write-back
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NROW; r++) acc[r] <= '0;
        end else if (s3.v) begin
            acc[s3.row] <= s3.sum;
        end
    end

    assign rd_data = acc[rd_row];
    assign busy    = s1.v || s2.v;
    assign wb_last = s3.v && s3.last;

    p_wb_latency_r8: assert property (@(posedge clk) disable iff (rst)
        iss_v |-> ##3 s3.v);
    p_row_rises_r3: assert property (@(posedge clk) disable iff (rst)
        (s1.v && !s1.first) |-> ($past(s1.v) && s1.row > $past(s1.row)));
    p_filler_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (s1.v && s1.code == '0) |-> (s1.w == '0));
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (s2.v && accv_s >= 0 && prod_sh >= 0) |=> (s3.sum >= $past(accv_s)));
    p_adjacent_rows_r7: assert property (@(posedge clk) disable iff (rst)
        (s1.v && s2.v) |-> (s1.row != s2.row));
endmodule

// File: rtl/csc_pe.sv
module csc_pe
    import cscpe_pkg::*;
#(
    parameter int NCOL   = 8,
    parameter int NWORD  = 8,
    parameter int NROW   = 32,
    parameter int QDEPTH = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [$clog2(NCOL)-1:0]          in_col,
    input  logic [DW-1:0]                    in_act,
    output logic                             in_ready,
    input  logic                             ptr_we,
    input  logic [$clog2(NCOL+1)-1:0]        ptr_waddr,
    input  logic [$clog2(NWORD*EPW+1)-1:0]   ptr_wdata,
    input  logic                             mem_we,
    input  logic [$clog2(NWORD)-1:0]         mem_waddr,
    input  logic [MEMW-1:0]                  mem_wdata,
    input  logic                             cb_we,
    input  logic [CODEW-1:0]                 cb_waddr,
    input  logic [DW-1:0]                    cb_wdata,
    input  logic [$clog2(NROW)-1:0]          rd_row,
    output logic [DW-1:0]                    rd_data,
    output logic                             done
);
    localparam int COLW = $clog2(NCOL);
    localparam int PW   = $clog2(NWORD * EPW + 1);
    localparam int IDXW = $clog2(NWORD * EPW);
    localparam int QW   = COLW + DW;

    logic [QW-1:0]   q_head;
    logic            q_empty, q_full, q_pop;
    logic [PW-1:0]   p_lo, p_hi, cur, lim;
    sq_state_t       st;
    sword_t          act_q;
    logic            first_q, iss_v, iss_last, busy, wb_last;
    entry_t          ent;

    cscpe_queue #(.W(QW), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst(rst), .push(in_valid), .din({in_col, in_act}),
        .pop(q_pop), .dout(q_head), .empty(q_empty), .full(q_full)
    );

    cscpe_ptr_banks #(.NCOL(NCOL), .PW(PW)) u_ptr (
        .clk(clk), .we(ptr_we), .waddr(ptr_waddr), .wdata(ptr_wdata),
        .col(q_head[QW-1:DW]), .p_lo(p_lo), .p_hi(p_hi)
    );

    cscpe_spmat #(.NWORD(NWORD)) u_spmat (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .idx(cur[IDXW-1:0]), .ent(ent)
    );

    cscpe_pipe #(.NROW(NROW)) u_pipe (
        .clk(clk), .rst(rst), .iss_v(iss_v), .iss_ent(ent), .iss_act(act_q),
        .iss_first(first_q), .iss_last(iss_last), .cb_we(cb_we),
        .cb_waddr(cb_waddr), .cb_wdata(cb_wdata), .rd_row(rd_row),
        .rd_data(rd_data), .busy(busy), .wb_last(wb_last)
    );

    assign in_ready = !q_full;
    assign q_pop    = (st == SQ_IDLE) && !q_empty;
    assign iss_v    = (st == SQ_WALK);
    assign iss_last = (cur + PW'(1) == lim);
    assign done     = wb_last && q_empty && (st == SQ_IDLE) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            cur     <= '0;
            lim     <= '0;
            act_q   <= '0;
            first_q <= 1'b0;
        end else begin
            unique case (st)
                SQ_IDLE: if (!q_empty && p_lo != p_hi) begin
                    st      <= SQ_WALK;
                    cur     <= p_lo;
                    lim     <= p_hi;
                    act_q   <= q_head[DW-1:0];
                    first_q <= 1'b1;
                end
                SQ_WALK: begin
                    first_q <= 1'b0;
                    cur     <= cur + PW'(1);
                    if (iss_last) st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    p_walk_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_WALK) |-> (cur < lim));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/sim_csc_pe.sv
`timescale 1ns/1ps
module sim_csc_pe;
    import cscpe_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_col = '0;
    logic [15:0] in_act = '0;
    logic        in_ready;
    logic        ptr_we = 1'b0;
    logic [3:0]  ptr_waddr = '0;
    logic [6:0]  ptr_wdata = '0;
    logic        mem_we = 1'b0;
    logic [2:0]  mem_waddr = '0;
    logic [63:0] mem_wdata = '0;
    logic        cb_we = 1'b0;
    logic [3:0]  cb_waddr = '0;
    logic [15:0] cb_wdata = '0;
    logic [4:0]  rd_row = '0;
    logic [15:0] rd_data;
    logic        done;

    csc_pe u0 (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0]         ent  [64];
    int                 ptrv [9];
    logic signed [15:0] cbv  [16];
    logic signed [15:0] expv [32];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired got %0d expected below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic signed [15:0] sat(input longint v);
        if (v > 32767)  return 16'sd32767;
        if (v < -32768) return -16'sd32768;
        return v[15:0];
    endfunction

    // expected effect of one column request, from the requirements
    task automatic model_col(input int j, input logic signed [15:0] a);
        int row = 0;
        for (int k = ptrv[j]; k < ptrv[j+1]; k++) begin
            int code = ent[k][3:0];
            int run  = ent[k][7:4];
            logic signed [31:0] p;
            row = (k == ptrv[j]) ? run : row + run + 1;
            if (code != 0) begin
                p = cbv[code] * a;
                expv[row] = sat(longint'(expv[row]) + longint'(p >>> 8));
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cmp_all(input string req);
        for (int r = 0; r < 32; r++) begin
            @(negedge clk);
            rd_row = 5'(r);
            #0.5;
            chk($signed(rd_data) == expv[r], req, $signed(rd_data), expv[r]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 32; r++) expv[r] = '0;
    endtask

    task automatic run_cycles(input int n, output int dones);
        dones = 0;
        repeat (n) begin
            @(negedge clk);
            if (done) dones++;
        end
    endtask

    task automatic push_one(input int c, input logic signed [15:0] a);
        @(negedge clk);
        in_valid = 1'b1;
        in_col = 3'(c);
        in_act = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [7:0] mk(input int code, input int run);
        return {4'(run), 4'(code)};
    endfunction

    task automatic load_all();
        int n = 0;
        for (int k = 0; k < 64; k++) ent[k] = '0;
        // column 0: rows 2,3,9,11
        ptrv[0] = n;
        ent[n++] = mk(3, 2); ent[n++] = mk(7, 0); ent[n++] = mk(12, 5); ent[n++] = mk(1, 1);
        // column 1: filler to row 15, then rows 19,20
        ptrv[1] = n;
        ent[n++] = mk(0, 15); ent[n++] = mk(5, 3); ent[n++] = mk(9, 0);
        // column 2: empty
        ptrv[2] = n;
        // column 3: rows 0..7
        ptrv[3] = n;
        for (int i = 0; i < 8; i++) ent[n++] = mk(i + 1, 0);
        // column 4: rows 1,7 ; column 5: rows 7,8
        ptrv[4] = n;
        ent[n++] = mk(4, 1); ent[n++] = mk(6, 5);
        ptrv[5] = n;
        ent[n++] = mk(15, 7); ent[n++] = mk(11, 0);
        // column 6: row 0, largest code
        ptrv[6] = n;
        ent[n++] = mk(15, 0);
        ptrv[7] = n;
        ptrv[8] = n;
        for (int i = 0; i < 16; i++) cbv[i] = 16'((i - 8) * 96);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            cb_we = 1'b1; cb_waddr = 4'(i);
            cb_wdata = (i == 0) ? 16'd1234 : cbv[i];
        end
        for (int j = 0; j < 9; j++) begin
            @(negedge clk);
            cb_we = 1'b0;
            ptr_we = 1'b1; ptr_waddr = 4'(j); ptr_wdata = 7'(ptrv[j]);
        end
        for (int w = 0; w < 8; w++) begin
            logic [63:0] wd;
            for (int b = 0; b < 8; b++) wd[b*8 +: 8] = ent[w*8 + b];
            @(negedge clk);
            ptr_we = 1'b0;
            mem_we = 1'b1; mem_waddr = 3'(w); mem_wdata = wd;
        end
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
        chk(done == 1'b0, "R10 done after reset", done, 0);
        cmp_all("R10 accumulators after reset");
    endtask

    task automatic t_single();
        int d;
        do_reset();
        push_one(0, 16'sd256);
        model_col(0, 16'sd256);
        run_cycles(20, d);
        chk(d == 1, "R9 one done pulse", d, 1);
        cmp_all("R1 R2 R3 R5 single column");
    endtask

    task automatic t_filler();
        int d;
        do_reset();
        push_one(1, 16'sd512);
        model_col(1, 16'sd512);
        run_cycles(20, d);
        chk(d == 1, "R9 done after filler column", d, 1);
        cmp_all("R4 R3 filler column");
    endtask

    task automatic t_empty();
        int d;
        do_reset();
        push_one(2, 16'sd700);
        run_cycles(15, d);
        cmp_all("R2 empty column");
    endtask

    task automatic t_full();
        int d;
        do_reset();
        @(negedge clk);
        in_valid = 1'b1; in_col = 3'd3; in_act = 16'sd100;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R10 queue full", in_ready, 0);
        for (int i = 0; i < 5; i++) model_col(3, 16'sd100);
        run_cycles(80, d);
        chk(in_ready == 1'b1, "R10 ready after drain", in_ready, 1);
        chk(d == 1, "R9 single done after burst", d, 1);
        cmp_all("R11 burst of five");
    endtask

    task automatic t_b2b();
        int d;
        do_reset();
        @(negedge clk);
        in_valid = 1'b1; in_col = 3'd4; in_act = 16'sd300;
        @(negedge clk);
        in_col = 3'd5; in_act = -16'sd200;
        @(negedge clk);
        in_valid = 1'b0;
        model_col(4, 16'sd300);
        model_col(5, -16'sd200);
        run_cycles(30, d);
        chk(d == 1, "R9 done once for two columns", d, 1);
        cmp_all("R7 R11 shared row across columns");
    endtask

    task automatic t_sat();
        int d;
        do_reset();
        push_one(6, 16'sd32767);
        model_col(6, 16'sd32767);
        run_cycles(15, d);
        cmp_all("R6 positive saturation");
        push_one(6, -16'sd32768);
        push_one(6, -16'sd32768);
        model_col(6, -16'sd32768);
        model_col(6, -16'sd32768);
        run_cycles(25, d);
        cmp_all("R6 negative saturation");
    endtask

    initial begin
        load_all();
        t_reset();
        t_single();
        t_filler();
        t_empty();
        t_full();
        t_b2b();
        t_sat();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule